// File: doc/BRIEF.md
# Adaptive Write-Verify-Rewrite Controller

This controller stores one 64-bit word into a memory array whose cells switch at random, and it guarantees that the stored value is correct. When a request is accepted, the controller counts the set bits of the incoming word and places that count in one of five weight classes. The weight class and a temperature code together select a write pulse length from a small programmable table. The selection is combinational, so it adds no cycle to the request.

The controller then runs a loop. It drives a write strobe for the selected number of cycles, reads the same location back over a fixed verify latency, and compares the result with the intended word. On a mismatch it writes again with the same pulse length. On a match it reports completion together with the number of pulses it spent. A programmable limit on the number of pulses turns an endless retry into a completion that carries an error flag. The analog behaviour of the cells lies outside the block, so the array is reached only through the strobe, address, data and pulse-length outputs and the read-data input.

Top module: `wvr_ctrl`

## Requirements
- R1: A request is taken on a clock edge where `req_i` and `ready_o` are both high. `ready_o` is low from the next cycle through the completion cycle, and it is high again in the cycle after completion.
- R2: The number of set bits in `data_i` maps to weight class 0 for 0 bits, 1 for 1 bit, 2 for 2 to 8 bits, 3 for 9 to 36 bits and 4 for 37 to 64 bits.
- R3: The pulse table holds one 8-bit entry per weight class (0..4) and temperature code (0..3), and every entry resets to 4. A configuration write with class index `cfg_bin_i` below 5 updates the entry on the next clock edge. The entry is read in the acceptance cycle, so a configuration write made later does not change the pulse length of the write already in progress.
- R4: Each write pulse holds `arr_we_o` high for exactly the selected number of cycles, with a programmed value of 0 treated as 1. `arr_pulse_o` shows that length. `arr_addr_o` and `arr_wdata_o` hold the accepted address and data.
- R5: After each pulse, `arr_re_o` is high for RD_LAT (default 2) cycles at the same address. `arr_rdata_i` is sampled in the last of those cycles, and one compare cycle follows. The two strobes are never high together.
- R6: If the word read back equals the accepted word, the operation completes. Otherwise another pulse of the same length starts in the cycle after the compare.
- R7: `iter_o` holds the number of pulses issued by the current or last operation, saturates at 15, and is cleared when a request is accepted.
- R8: `max_iter_i` is captured at acceptance. If it is nonzero and a mismatching compare brings the pulse count to that value, the operation completes with `err_o` high. A value of 0 allows unlimited retries.
- R9: `done_o` is high for exactly one cycle per operation. `err_o` is high only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request |
| ready_o | output | 1 | Controller idle and able to take a request |
| data_i | input | 64 | Word to store |
| addr_i | input | AW (10) | Target location |
| temp_i | input | 2 | Temperature code |
| max_iter_i | input | 4 | Pulse limit, 0 means unlimited |
| cfg_we_i | input | 1 | Pulse table write enable |
| cfg_bin_i | input | 3 | Weight class of the entry to write |
| cfg_temp_i | input | 2 | Temperature code of the entry to write |
| cfg_width_i | input | 8 | Pulse length in cycles to write |
| arr_we_o | output | 1 | Array write strobe |
| arr_re_o | output | 1 | Array read strobe |
| arr_addr_o | output | AW (10) | Array address |
| arr_wdata_o | output | 64 | Array write data |
| arr_pulse_o | output | 8 | Length of the current pulse in cycles |
| arr_rdata_i | input | 64 | Array read data |
| done_o | output | 1 | Operation complete, one cycle |
| err_o | output | 1 | Pulse limit reached without a match, valid with done_o |
| iter_o | output | 4 | Pulses issued, saturating |

## Verification
The hardest conditions to reach are those that need many consecutive verify failures: the 15-pulse saturation, and the exact pulse on which the limit is hit. A failure count fixed for each operation drives them. The bench's array model returns a word with one bit corrupted on every read until that many pulses have gone by, so 18 failures with no limit reach saturation, and limits just above and below the failure count test the error boundary. A configuration write issued while an operation is already pulsing checks that the pulse length was captured at acceptance. Words built with exactly 0, 1, 2, 8, 9, 36, 37 and 64 set bits, each rotated to a different position, exercise every class edge.

// File: rtl/wvr_pkg.sv
package wvr_pkg;
  localparam int NBIN    = 5;
  localparam int BIN_W   = 3;
  localparam int C2_HI   = 8;   // upper weight of class 2
  localparam int C3_HI   = 36;  // upper weight of class 3

  typedef enum logic [2:0] {
    S_IDLE,
    S_WRITE,
    S_READ,
    S_CMP,
    S_DONE
  } wvr_state_e;
endpackage

// File: rtl/wvr_weight_bin.sv
module wvr_weight_bin #(
  parameter int DW = 64
) (
  input  logic [DW-1:0]              data_i,
  output logic [wvr_pkg::BIN_W-1:0]  bin_o
);
  localparam int CW = $clog2(DW + 1);

  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < DW; i++) ones = ones + CW'(data_i[i]);
  end

  always_comb begin
    if (ones == '0)                          bin_o = 3'd0;
    else if (ones == CW'(1))                 bin_o = 3'd1;
    else if (ones <= CW'(wvr_pkg::C2_HI))    bin_o = 3'd2;
    else if (ones <= CW'(wvr_pkg::C3_HI))    bin_o = 3'd3;
    else                                     bin_o = 3'd4;
  end
endmodule

// File: rtl/wvr_width_table.sv
module wvr_width_table #(
  parameter int TW    = 2,
  parameter int WW    = 8,
  parameter int DEF_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_we_i,
  input  logic [wvr_pkg::BIN_W-1:0]  cfg_bin_i,
  input  logic [TW-1:0]              cfg_temp_i,
  input  logic [WW-1:0]              cfg_width_i,
  input  logic [wvr_pkg::BIN_W-1:0]  rd_bin_i,
  input  logic [TW-1:0]              rd_temp_i,
  output logic [WW-1:0]              rd_width_o
);
  localparam int NTEMP = 1 << TW;
  localparam int NENT  = wvr_pkg::NBIN * NTEMP;

  logic [WW-1:0] ent_q [NENT];

  for (genvar b = 0; b < wvr_pkg::NBIN; b++) begin : g_bin
    for (genvar t = 0; t < NTEMP; t++) begin : g_temp
      logic hit;
      assign hit = cfg_we_i && (cfg_bin_i == wvr_pkg::BIN_W'(b))
                            && (cfg_temp_i == TW'(t));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  ent_q[b*NTEMP+t] <= WW'(DEF_W);
        else if (hit) ent_q[b*NTEMP+t] <= cfg_width_i;
      end
    end
  end

  always_comb begin
    rd_width_o = ent_q[0];
    for (int b = 0; b < wvr_pkg::NBIN; b++)
      for (int t = 0; t < NTEMP; t++)
        if (rd_bin_i == wvr_pkg::BIN_W'(b) && rd_temp_i == TW'(t))
          rd_width_o = ent_q[b*NTEMP+t];
  end
endmodule

// File: rtl/wvr_seq.sv
module wvr_seq #(
  parameter int DW     = 64,
  parameter int AW     = 10,
  parameter int WW     = 8,
  parameter int IW     = 4,
  parameter int RD_LAT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [DW-1:0] data_i,
  input  logic [AW-1:0] addr_i,
  input  logic [IW-1:0] max_iter_i,
  input  logic [WW-1:0] width_sel_i,
  input  logic [DW-1:0] arr_rdata_i,
  output logic          ready_o,
  output logic          arr_we_o,
  output logic          arr_re_o,
  output logic [AW-1:0] arr_addr_o,
  output logic [DW-1:0] arr_wdata_o,
  output logic [WW-1:0] arr_pulse_o,
  output logic          done_o,
  output logic          err_o,
  output logic [IW-1:0] iter_o
);
  import wvr_pkg::*;

  localparam logic [WW-1:0] RD_LAST = WW'(RD_LAT - 1);

  wvr_state_e    state_q;
  logic [WW-1:0] cnt_q, width_q, width_eff;
  logic [IW-1:0] iter_q, iter_nx, max_q;
  logic [DW-1:0] data_q, rd_q;
  logic [AW-1:0] addr_q;
  logic          fail_q;

  assign width_eff = (width_sel_i == '0) ? WW'(1) : width_sel_i;
  assign iter_nx   = (iter_q == '1) ? iter_q : iter_q + IW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      width_q <= '0;
      iter_q  <= '0;
      max_q   <= '0;
      data_q  <= '0;
      rd_q    <= '0;
      addr_q  <= '0;
      fail_q  <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_i) begin
          data_q  <= data_i;
          addr_q  <= addr_i;
          max_q   <= max_iter_i;
          width_q <= width_eff;
          cnt_q   <= width_eff - WW'(1);
          iter_q  <= '0;
          fail_q  <= 1'b0;
          state_q <= S_WRITE;
        end
        S_WRITE: begin
          if (cnt_q == '0) begin
            cnt_q   <= RD_LAST;
            state_q <= S_READ;
          end else begin
            cnt_q <= cnt_q - WW'(1);
          end
        end
        S_READ: begin
          if (cnt_q == '0) begin
            rd_q    <= arr_rdata_i;
            state_q <= S_CMP;
          end else begin
            cnt_q <= cnt_q - WW'(1);
          end
        end
        S_CMP: begin
          iter_q <= iter_nx;
          if (rd_q == data_q) begin
            state_q <= S_DONE;
          end else if (max_q != '0 && iter_nx >= max_q) begin
            fail_q  <= 1'b1;
            state_q <= S_DONE;
          end else begin
            cnt_q   <= width_q - WW'(1);
            state_q <= S_WRITE;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ready_o     = (state_q == S_IDLE);
  assign arr_we_o    = (state_q == S_WRITE);
  assign arr_re_o    = (state_q == S_READ);
  assign arr_addr_o  = addr_q;
  assign arr_wdata_o = data_q;
  assign arr_pulse_o = width_q;
  assign done_o      = (state_q == S_DONE);
  assign err_o       = done_o && fail_q;
  assign iter_o      = iter_q;
endmodule

// File: rtl/wvr_ctrl.sv
module wvr_ctrl #(
  parameter int DW     = 64,
  parameter int AW     = 10,
  parameter int TW     = 2,
  parameter int WW     = 8,
  parameter int IW     = 4,
  parameter int RD_LAT = 2,
  parameter int DEF_W  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  output logic                       ready_o,
  input  logic [DW-1:0]              data_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [TW-1:0]              temp_i,
  input  logic [IW-1:0]              max_iter_i,
  input  logic                       cfg_we_i,
  input  logic [wvr_pkg::BIN_W-1:0]  cfg_bin_i,
  input  logic [TW-1:0]              cfg_temp_i,
  input  logic [WW-1:0]              cfg_width_i,
  output logic                       arr_we_o,
  output logic                       arr_re_o,
  output logic [AW-1:0]              arr_addr_o,
  output logic [DW-1:0]              arr_wdata_o,
  output logic [WW-1:0]              arr_pulse_o,
  input  logic [DW-1:0]              arr_rdata_i,
  output logic                       done_o,
  output logic                       err_o,
  output logic [IW-1:0]              iter_o
);
  logic [wvr_pkg::BIN_W-1:0] bin;
  logic [WW-1:0]             width_sel;
  logic                      ready;

  wvr_weight_bin #(.DW(DW)) u_bin (
    .data_i (data_i),
    .bin_o  (bin)
  );

  wvr_width_table #(.TW(TW), .WW(WW), .DEF_W(DEF_W)) u_tbl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_bin_i   (cfg_bin_i),
    .cfg_temp_i  (cfg_temp_i),
    .cfg_width_i (cfg_width_i),
    .rd_bin_i    (bin),
    .rd_temp_i   (temp_i),
    .rd_width_o  (width_sel)
  );

  wvr_seq #(.DW(DW), .AW(AW), .WW(WW), .IW(IW), .RD_LAT(RD_LAT)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .data_i      (data_i),
    .addr_i      (addr_i),
    .max_iter_i  (max_iter_i),
    .width_sel_i (width_sel),
    .arr_rdata_i (arr_rdata_i),
    .ready_o     (ready),
    .arr_we_o    (arr_we_o),
    .arr_re_o    (arr_re_o),
    .arr_addr_o  (arr_addr_o),
    .arr_wdata_o (arr_wdata_o),
    .arr_pulse_o (arr_pulse_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .iter_o      (iter_o)
  );

  assign ready_o = ready;
endmodule

// File: rtl/wvr_ctrl_chk.sv
module wvr_ctrl_chk #(
  parameter int AW = 10,
  parameter int IW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          ready_o,
  input logic          arr_we_o,
  input logic          arr_re_o,
  input logic [AW-1:0] arr_addr_o,
  input logic          done_o,
  input logic          err_o,
  input logic [IW-1:0] iter_o
);
  a_r1_accept_starts_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> (!ready_o && arr_we_o));

  a_r1_busy_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ready_o);

  a_r5_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && $past(!ready_o)) |-> $stable(arr_addr_o));

  a_r5_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arr_we_o && arr_re_o));

  a_r5_read_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(arr_we_o) |-> arr_re_o);

  a_r7_iter_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && $past(!ready_o) && $past(iter_o) == {IW{1'b1}}) |-> iter_o == {IW{1'b1}});

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && ready_o));

  a_r9_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
endmodule

bind wvr_ctrl wvr_ctrl_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .ready_o    (ready_o),
  .arr_we_o   (arr_we_o),
  .arr_re_o   (arr_re_o),
  .arr_addr_o (arr_addr_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .iter_o     (iter_o)
);

// File: tb/wvr_ctrl_tb_top.sv
module wvr_ctrl_tb_top;
  localparam int L = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [63:0] data = '0;
  logic [9:0]  addr = '0;
  logic [1:0]  temp = '0;
  logic [3:0]  maxit = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_bin = '0;
  logic [1:0]  cfg_temp = '0;
  logic [7:0]  cfg_width = '0;
  logic [63:0] rdata = '0;
  logic        ready, we, re, done, err;
  logic [9:0]  a_addr;
  logic [63:0] a_wdata;
  logic [7:0]  pulse;
  logic [3:0]  iter;

  wvr_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ready_o(ready),
    .data_i(data), .addr_i(addr), .temp_i(temp), .max_iter_i(maxit),
    .cfg_we_i(cfg_we), .cfg_bin_i(cfg_bin), .cfg_temp_i(cfg_temp),
    .cfg_width_i(cfg_width), .arr_we_o(we), .arr_re_o(re),
    .arr_addr_o(a_addr), .arr_wdata_o(a_wdata), .arr_pulse_o(pulse),
    .arr_rdata_i(rdata), .done_o(done), .err_o(err), .iter_o(iter)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  int          mtbl [5][4];
  int          cyc = 0, c0 = 0;
  bit          m_busy = 0;
  int          m_w, m_p, m_n, m_nfail;
  bit          m_err;
  logic [63:0] m_data;
  logic [9:0]  m_addr;
  string       m_tag = "R3";

  function automatic int bin_of(input logic [63:0] d);
    int k = $countones(d);
    if (k == 0) return 0;
    if (k == 1) return 1;
    if (k <= 8) return 2;
    if (k <= 36) return 3;
    return 4;
  endfunction

  always @(posedge clk) begin
    bit pre;
    pre = !m_busy;
    cyc = cyc + 1;
    if (!rst_n) begin
      m_busy = 0;
      for (int b = 0; b < 5; b++) for (int t = 0; t < 4; t++) mtbl[b][t] = 4;
    end else begin
      if (m_busy && (cyc - c0) > m_n * m_p) m_busy = 0;
      if (pre && req) begin
        m_busy  = 1;
        c0      = cyc;
        m_w     = mtbl[bin_of(data)][temp];
        if (m_w == 0) m_w = 1;
        m_p     = m_w + L + 1;
        m_data  = data;
        m_addr  = addr;
        m_n     = m_nfail + 1;
        m_err   = 0;
        if (maxit != 0 && m_nfail >= maxit) begin
          m_n   = maxit;
          m_err = 1;
        end
      end
      if (cfg_we && cfg_bin < 5) mtbl[cfg_bin][cfg_temp] = cfg_width;
    end
  end

  // array model and per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      int  off, j, r;
      bit  e_we, e_re, e_done, e_rdy;
      off = cyc - c0;
      e_we = 0; e_re = 0; e_done = 0; e_rdy = 1;
      j = 0; r = 0;
      if (m_busy) begin
        e_rdy = 0;
        if (off == m_n * m_p) e_done = 1;
        else begin
          j = off / m_p;
          r = off % m_p;
          e_we = (r < m_w);
          e_re = (r >= m_w) && (r < m_w + L);
        end
      end
      rdata = e_re ? ((j >= m_nfail) ? m_data : m_data ^ (64'd1 << ((j * 7) % 64))) : '0;
      chk(ready == e_rdy, "R1 ready", ready, e_rdy);
      chk(we == e_we, "R4 write strobe", we, e_we);
      chk(re == e_re, "R5 read strobe", re, e_re);
      chk(done == e_done, "R9 done", done, e_done);
      chk(err == (e_done && m_err), "R8 err", err, e_done && m_err);
      if (m_busy && off == 0) chk(pulse == 8'(m_w), m_tag, pulse, m_w);
      if (e_we) begin
        chk(pulse == 8'(m_w), "R4 pulse", pulse, m_w);
        chk(a_wdata == m_data, "R4 wdata", a_wdata, m_data);
      end
      if (e_we || e_re) chk(a_addr == m_addr, "R5 addr", a_addr, m_addr);
      if (e_done) chk(iter == 4'((m_n > 15) ? 15 : m_n), "R7 iter", iter,
                      (m_n > 15) ? 15 : m_n);
    end
  end

  function automatic logic [63:0] mk(input int k, input int rot);
    logic [63:0] b;
    b = (k >= 64) ? '1 : ((64'd1 << k) - 64'd1);
    return (rot == 0) ? b : ((b << rot) | (b >> (64 - rot)));
  endfunction

  task automatic cfg_wr(input int b, input int t, input int w);
    @(negedge clk);
    cfg_we = 1; cfg_bin = 3'(b); cfg_temp = 2'(t); cfg_width = 8'(w);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic op(input logic [63:0] d, input int a, input int t,
                    input int nf, input int mx, input string tag);
    @(negedge clk);
    while (m_busy) @(negedge clk);
    m_nfail = nf; m_tag = tag;
    req = 1; data = d; addr = 10'(a); temp = 2'(t); maxit = 4'(mx);
    @(negedge clk);
    req = 0; data = ~d; addr = ~addr; maxit = 4'(mx + 5);
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 1, "R1 reset ready", ready, 1);
    chk(done == 0 && we == 0 && re == 0, "R9 reset idle", {done, we, re}, 0);
    chk(iter == 0, "R7 reset iter", iter, 0);
    rst_n = 1;
    // default entry
    op('0, 1, 0, 0, 0, "R3 default width");
    for (int b = 0; b < 5; b++)
      for (int t = 0; t < 4; t++) cfg_wr(b, t, 2 + 3 * b + t);
    cfg_wr(2, 1, 0);
    cfg_wr(6, 0, 99);  // class index out of range
    // class boundaries
    op(mk(0, 0),   10, 3, 1, 0, "R2 weight 0");
    op(mk(1, 13),  11, 2, 0, 0, "R2 weight 1");
    op(mk(2, 40),  12, 0, 2, 0, "R2 weight 2");
    op(mk(8, 60),  13, 3, 0, 0, "R2 weight 8");
    op(mk(9, 5),   14, 1, 1, 0, "R2 weight 9");
    op(mk(36, 20), 15, 2, 2, 0, "R2 weight 36");
    op(mk(37, 31), 16, 0, 0, 0, "R2 weight 37");
    op(mk(64, 0),  17, 3, 1, 0, "R2 weight 64");
    op(mk(0, 0),   18, 0, 0, 0, "R3 class 0 after bad index");
    // zero entry runs one cycle
    op(mk(5, 3), 20, 1, 2, 0, "R4 zero width");
    // table write during an operation
    fork
      op(mk(20, 7), 30, 2, 2, 0, "R3 captured width");
      begin repeat (4) @(negedge clk); cfg_wr(3, 2, 9); end
    join
    op(mk(20, 9), 31, 2, 0, 0, "R3 updated width");
    // limits and retries
    op(mk(3, 1),  40, 0, 5, 3, "R8 limit hit");
    op(mk(3, 2),  41, 0, 1, 2, "R8 match on last allowed");
    op(mk(3, 3),  42, 0, 2, 2, "R8 fail at limit");
    op(mk(12, 4), 43, 1, 18, 0, "R7 saturation");
    op(mk(40, 8), 44, 3, 3, 0, "R6 rewrite then match");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule